// File: doc/BRIEF.md
# Character Display Frame Timer with Sync Interrupt Routing

This block keeps the raster timing for a 32-column by 16-row text screen. A horizontal counter steps through the clocks of one scanline. A vertical counter steps through the scanlines of one frame, with 312 lines per frame by default. At the first clock of every frame the block raises a one-clock field-sync pulse.

A two-bit routing input decides what that pulse does to the processor. In the disabled mode, which is the reset default, it does nothing. In the maskable mode it sets an interrupt request level, which stays high until software acknowledges it. In the non-maskable mode it produces a one-clock pulse every frame.

During the active part of the screen the block also generates the read address into a 512-byte character buffer. Each character cell spans a fixed number of clocks across and a fixed number of scanlines down. Outside the active window the address holds its last value. The scanline length and the window placement are parameters, so a short frame can be run for testing. Pixel shifting, the glyph table and analog output belong to other blocks.

Top module: `frame_sync_timer`

## Requirements
- R1: A frame is FRAME_LINES scanlines of LINE_CLKS clocks. `field_sync` is high for exactly one clock per frame. It is registered: it is high in the cycle after the raster position (line 0, clock 0) has been reached. The first pulse follows the first clock edge after reset is released, and pulses then repeat every FRAME_LINES*LINE_CLKS clocks.
- R2: While `rst_n` is sampled low at a rising edge, every output goes to 0 and the raster position returns to line 0, clock 0.
- R3: `route_mode` is sampled at the frame-start edge. Code 2'b00 (disabled) and code 2'b11 (reserved, treated as disabled) neither set `irq_req` nor pulse `nmi_pulse`.
- R4: With code 2'b01 (maskable), `irq_req` rises together with `field_sync`. It then stays high until `irq_ack` is sampled high, and it is low from the next cycle on.
- R5: When a frame start under code 2'b01 and a high `irq_ack` fall on the same edge, the new request wins and `irq_req` is high afterwards.
- R6: With code 2'b10 (non-maskable), `nmi_pulse` is high for one clock, coincident with `field_sync`, in every such frame. `irq_ack` has no effect on it.
- R7: `vram_rd` is high in the cycle after each raster position inside the active window. The window covers lines V_START to V_START+ROWS*ROW_LINES-1 and clocks H_START to H_START+COLS*CHAR_CLKS-1. `vram_rd` is low after every other position.
- R8: When `vram_rd` is high, `vram_addr` = row*COLS + col. Here row = (line-V_START)/ROW_LINES and col = (clock-H_START)/CHAR_CLKS. With the defaults this is row*32 + column in a 9-bit address.
- R9: Outside the active window `vram_addr` holds its last value, and it is 0 after reset. Every full frame visits every cell address, 0 through COLS*ROWS-1.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Timing clock |
| rst_n | input | 1 | Synchronous reset, active low |
| route_mode | input | 2 | Sync routing: 00 off, 01 maskable, 10 non-maskable, 11 off |
| irq_ack | input | 1 | Clears the pending maskable request |
| field_sync | output | 1 | One-clock frame-start pulse |
| irq_req | output | 1 | Maskable interrupt level |
| nmi_pulse | output | 1 | Non-maskable interrupt pulse |
| vram_rd | output | 1 | Character fetch strobe in the active window |
| vram_addr | output | ADDR_W (9) | Character cell read address |

## Verification
A wrong horizontal or vertical count would move `field_sync` away from its expected clock. The reference model compares every cycle, so a pulse that is one clock early or late shows up within a frame. A fault in the window or cell arithmetic shows in `vram_rd` or `vram_addr` on the first clock of the active window. From that point on it repeats on every scanline. Routing faults (a request under a disabled code, a lost request, acknowledge winning over a new set, or a pulse that lasts two clocks) show at the frame-start edge and the cycle after it. The bench therefore crosses frame starts under all four codes, with acknowledge both idle and active at that edge.

// File: rtl/fst_pkg.sv
// Shared types for the frame timer: the encoding of the sync routing input.
package fst_pkg;

    // Routing of the frame-start pulse; 11 is reserved and behaves as off.
    typedef enum logic [1:0] {
        ROUTE_OFF  = 2'b00,
        ROUTE_IRQ  = 2'b01,
        ROUTE_NMI  = 2'b10,
        ROUTE_RSVD = 2'b11
    } route_e;

endpackage

// File: rtl/fst_raster.sv
// Raster position counter.
// Steps a horizontal count through LINE_CLKS clocks and a vertical count
// through FRAME_LINES scanlines, and flags the first clock of each frame.
// Assumes LINE_CLKS >= 2 and FRAME_LINES >= 2.
module fst_raster #(
    parameter int LINE_CLKS   = 228,
    parameter int FRAME_LINES = 312,
    parameter int HW          = 8,
    parameter int VW          = 9
) (
    input  logic          clk,
    input  logic          rst_n,
    output logic [HW-1:0] h_pos,
    output logic [VW-1:0] v_pos,
    output logic          frame_start
);

    localparam logic [HW-1:0] H_LAST = HW'(LINE_CLKS - 1);
    localparam logic [VW-1:0] V_LAST = VW'(FRAME_LINES - 1);

    // Advance the clock-in-line count, and the line count on each wrap.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            h_pos <= '0;
            v_pos <= '0;
        end else if (h_pos == H_LAST) begin
            h_pos <= '0;
            v_pos <= (v_pos == V_LAST) ? '0 : v_pos + 1'b1;
        end else begin
            h_pos <= h_pos + 1'b1;
        end
    end

    // Frame origin flag.
    assign frame_start = (h_pos == '0) && (v_pos == '0);

    // R1
    line_wrap_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (h_pos == H_LAST) |=> (h_pos == '0));

    // R1
    line_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (v_pos <= V_LAST) && (h_pos <= H_LAST));

endmodule

// File: rtl/fst_cell_fetch.sv
// Character cell address generator.
// Turns the raster position into a cell read address while the position
// lies inside the active window, and holds the address elsewhere.
// Outputs are registered, one cycle behind the raster position.
// Assumes H_START > 0 and V_START > 0, and that the window fits in the frame.
module fst_cell_fetch #(
    parameter int HW        = 8,
    parameter int VW        = 9,
    parameter int AW        = 9,
    parameter int COLS      = 32,
    parameter int ROWS      = 16,
    parameter int CHAR_CLKS = 4,
    parameter int ROW_LINES = 12,
    parameter int H_START   = 16,
    parameter int V_START   = 40
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic [HW-1:0] h_pos,
    input  logic [VW-1:0] v_pos,
    output logic          fetch_en,
    output logic [AW-1:0] cell_addr
);

    localparam logic [31:0] H_LO = 32'(H_START);
    localparam logic [31:0] H_HI = 32'(H_START + COLS * CHAR_CLKS);
    localparam logic [31:0] V_LO = 32'(V_START);
    localparam logic [31:0] V_HI = 32'(V_START + ROWS * ROW_LINES);

    logic [31:0]   h_w, v_w, h_off, v_off, col_idx, row_idx;
    logic          in_window;
    logic [AW-1:0] addr_next;

    assign h_w   = 32'(h_pos);
    assign v_w   = 32'(v_pos);
    assign h_off = h_w - H_LO;
    assign v_off = v_w - V_LO;

    // Window membership of the current raster position.
    assign in_window = (h_w >= H_LO) && (h_w < H_HI) && (v_w >= V_LO) && (v_w < V_HI);

    // Column index: a shift when the cell width is a power of two, else a divide.
    generate
        if ((CHAR_CLKS & (CHAR_CLKS - 1)) == 0) begin : g_col_shift
            assign col_idx = h_off >> $clog2(CHAR_CLKS);
        end else begin : g_col_div
            assign col_idx = h_off / 32'(CHAR_CLKS);
        end
    endgenerate

    // Row index: the same choice for the cell height in scanlines.
    generate
        if ((ROW_LINES & (ROW_LINES - 1)) == 0) begin : g_row_shift
            assign row_idx = v_off >> $clog2(ROW_LINES);
        end else begin : g_row_div
            assign row_idx = v_off / 32'(ROW_LINES);
        end
    endgenerate

    // Linear cell address, row-major.
    assign addr_next = AW'(row_idx * 32'(COLS) + col_idx);

    // Register the fetch strobe, and load the address only inside the window.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            fetch_en  <= 1'b0;
            cell_addr <= '0;
        end else begin
            fetch_en <= in_window;
            if (in_window) begin
                cell_addr <= addr_next;
            end
        end
    end

    // R9
    addr_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !in_window |=> $stable(cell_addr));

    // R8
    addr_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
        fetch_en |-> (32'(cell_addr) < 32'(COLS * ROWS)));

endmodule

// File: rtl/fst_sync_router.sv
// Frame sync pulse and interrupt routing.
// Registers the frame-start flag as the sync pulse and steers it, according
// to the routing code sampled at that edge, to a held maskable request or
// to a one-clock non-maskable pulse. A new request wins over an acknowledge.
module fst_sync_router
    import fst_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       frame_start,
    input  logic [1:0] route_mode,
    input  logic       irq_ack,
    output logic       field_sync,
    output logic       irq_req,
    output logic       nmi_pulse
);

    route_e mode;
    logic   set_irq;

    assign mode    = route_e'(route_mode);
    assign set_irq = frame_start && (mode == ROUTE_IRQ);

    // Sync pulse and non-maskable pulse, both one clock wide.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            field_sync <= 1'b0;
            nmi_pulse  <= 1'b0;
        end else begin
            field_sync <= frame_start;
            nmi_pulse  <= frame_start && (mode == ROUTE_NMI);
        end
    end

    // Maskable request level: set at frame start, cleared by acknowledge.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            irq_req <= 1'b0;
        end else if (set_irq) begin
            irq_req <= 1'b1;
        end else if (irq_ack) begin
            irq_req <= 1'b0;
        end
    end

    // R1
    sync_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
        field_sync |=> !field_sync);

    // R4
    irq_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (irq_req && !irq_ack) |=> irq_req);

    // R5
    irq_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (frame_start && (route_mode == 2'b01)) |=> irq_req);

    // R3
    nmi_src_chk: assert property (@(posedge clk) disable iff (!rst_n)
        nmi_pulse |-> ($past(route_mode) == 2'b10));

    // R6
    nmi_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
        nmi_pulse |=> !nmi_pulse);

endmodule

// File: rtl/frame_sync_timer.sv
// Frame timer for a character display, with sync interrupt routing.
// Chains the raster counter, the cell address generator and the sync
// router. All outputs are registered and reset to 0.
// Assumes the active window fits inside one line and one frame.
module frame_sync_timer #(
    parameter int LINE_CLKS   = 228,
    parameter int FRAME_LINES = 312,
    parameter int COLS        = 32,
    parameter int ROWS        = 16,
    parameter int CHAR_CLKS   = 4,
    parameter int ROW_LINES   = 12,
    parameter int H_START     = 16,
    parameter int V_START     = 40,
    localparam int ADDR_W     = $clog2(COLS * ROWS)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [1:0]        route_mode,
    input  logic              irq_ack,
    output logic              field_sync,
    output logic              irq_req,
    output logic              nmi_pulse,
    output logic              vram_rd,
    output logic [ADDR_W-1:0] vram_addr
);

    localparam int HW = $clog2(LINE_CLKS);
    localparam int VW = $clog2(FRAME_LINES);

    logic [HW-1:0] h_pos;
    logic [VW-1:0] v_pos;
    logic          frame_start;

    fst_raster #(
        .LINE_CLKS  (LINE_CLKS),
        .FRAME_LINES(FRAME_LINES),
        .HW         (HW),
        .VW         (VW)
    ) u_raster (
        .clk        (clk),
        .rst_n      (rst_n),
        .h_pos      (h_pos),
        .v_pos      (v_pos),
        .frame_start(frame_start)
    );

    fst_cell_fetch #(
        .HW       (HW),
        .VW       (VW),
        .AW       (ADDR_W),
        .COLS     (COLS),
        .ROWS     (ROWS),
        .CHAR_CLKS(CHAR_CLKS),
        .ROW_LINES(ROW_LINES),
        .H_START  (H_START),
        .V_START  (V_START)
    ) u_fetch (
        .clk      (clk),
        .rst_n    (rst_n),
        .h_pos    (h_pos),
        .v_pos    (v_pos),
        .fetch_en (vram_rd),
        .cell_addr(vram_addr)
    );

    fst_sync_router u_router (
        .clk        (clk),
        .rst_n      (rst_n),
        .frame_start(frame_start),
        .route_mode (route_mode),
        .irq_ack    (irq_ack),
        .field_sync (field_sync),
        .irq_req    (irq_req),
        .nmi_pulse  (nmi_pulse)
    );

    // R2
    reset_quiet_chk: assert property (@(posedge clk)
        !rst_n |=> (!field_sync && !irq_req && !nmi_pulse && !vram_rd && (vram_addr == '0)));

endmodule

// File: tb/frame_sync_timer_bench.sv
// Bench: a behavioural model of the raster position and routing rules,
// compared against the outputs after every clock edge.
module frame_sync_timer_bench;

    localparam int L     = 40;
    localparam int LINES = 312;
    localparam int COLS  = 32;
    localparam int ROWS  = 16;
    localparam int CPC   = 1;
    localparam int RH    = 2;
    localparam int HA    = 4;
    localparam int VA    = 3;
    localparam int FRAME = L * LINES;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic [1:0] route_mode = 2'b00;
    logic       irq_ack = 1'b0;
    logic       field_sync, irq_req, nmi_pulse, vram_rd;
    logic [8:0] vram_addr;

    always #2 clk = ~clk;

    frame_sync_timer #(
        .LINE_CLKS  (L),
        .FRAME_LINES(LINES),
        .COLS       (COLS),
        .ROWS       (ROWS),
        .CHAR_CLKS  (CPC),
        .ROW_LINES  (RH),
        .H_START    (HA),
        .V_START    (VA)
    ) u_frame_sync_timer (
        .clk       (clk),
        .rst_n     (rst_n),
        .route_mode(route_mode),
        .irq_ack   (irq_ack),
        .field_sync(field_sync),
        .irq_req   (irq_req),
        .nmi_pulse (nmi_pulse),
        .vram_rd   (vram_rd),
        .vram_addr (vram_addr)
    );

    int vectors = 0;
    int fails   = 0;
    int k       = 0;
    int edge_no = 0;
    int last_fs = -1;
    int max_addr = -1;
    int e_fs, e_irq, e_nmi, e_rd, e_addr;
    bit done = 1'b0;

    task automatic check(input string tag, input int act, input int exp);
        vectors++;
        if (act != exp) begin
            fails++;
            $display("FAIL %s actual=%0d expected=%0d (edge %0d)", tag, act, exp, edge_no);
        end
    endtask

    // One clock: drive at the falling edge, update the model, compare after the rise.
    task automatic step(input logic r, input logic [1:0] m, input logic a);
        int pos, v, h;
        @(negedge clk);
        rst_n = r; route_mode = m; irq_ack = a;
        @(posedge clk);
        #1;
        edge_no++;
        if (!r) begin
            k = 0; e_fs = 0; e_irq = 0; e_nmi = 0; e_rd = 0; e_addr = 0;
            last_fs = -1; max_addr = -1;
        end else begin
            pos = k % FRAME;
            k++;
            v = pos / L;
            h = pos % L;
            e_fs  = (pos == 0) ? 1 : 0;
            e_nmi = (pos == 0 && m == 2'b10) ? 1 : 0;
            if (pos == 0 && m == 2'b01) e_irq = 1;
            else if (a) e_irq = 0;
            e_rd = (v >= VA && v < VA + ROWS * RH && h >= HA && h < HA + COLS * CPC) ? 1 : 0;
            if (e_rd == 1) e_addr = ((v - VA) / RH) * COLS + (h - HA) / CPC;
        end
        check("R1/R2 field_sync", int'(field_sync), e_fs);
        check("R3/R4/R5 irq_req", int'(irq_req), e_irq);
        check("R3/R6 nmi_pulse", int'(nmi_pulse), e_nmi);
        check("R7 vram_rd", int'(vram_rd), e_rd);
        check("R8/R9 vram_addr", int'(vram_addr), e_addr);
        if (r && vram_rd && int'(vram_addr) > max_addr) max_addr = int'(vram_addr);
        if (r && field_sync) begin
            if (last_fs >= 0) begin
                check("R1 frame length", edge_no - last_fs, FRAME);
                check("R9 cells covered", max_addr, COLS * ROWS - 1);
            end
            last_fs = edge_no;
            max_addr = -1;
        end
    endtask

    // Step under a fixed code until the next raster position equals target.
    task automatic run_until(input logic [1:0] m, input int target);
        while ((k % FRAME) != target) step(1'b1, m, 1'b0);
    endtask

    initial begin
        repeat (4) step(1'b0, 2'b00, 1'b0);            // R2 reset state
        step(1'b1, 2'b00, 1'b0);                       // R1 first pulse, R3 off
        run_until(2'b00, 0);
        run_until(2'b01, 5000);                        // R4 request set
        step(1'b1, 2'b01, 1'b1);                       // R4 acknowledge
        run_until(2'b01, 0);
        repeat (3) step(1'b1, 2'b01, 1'b1);            // R5 set wins, then clear
        run_until(2'b01, 100);
        run_until(2'b10, 0);
        step(1'b1, 2'b10, 1'b1);                       // R6 ack has no effect
        run_until(2'b10, 0);                           // R6 second frame
        step(1'b1, 2'b10, 1'b0);
        run_until(2'b01, 0);                           // R4 pending across mode change
        step(1'b1, 2'b01, 1'b0);
        run_until(2'b11, 0);
        step(1'b1, 2'b11, 1'b0);                       // R3 reserved code
        run_until(2'b11, 300);
        repeat (3) step(1'b0, 2'b10, 1'b0);            // R2 mid-frame reset
        step(1'b1, 2'b10, 1'b0);
        run_until(2'b10, 0);
        repeat (50) step(1'b1, 2'b10, 1'b0);
        done = 1'b1;
        $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
        $finish;
    end

    initial begin
        #(4 * 200000);
        if (!done) begin
            fails++;
            $display("FAIL R1 watchdog actual=running expected=finished");
            $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
            $finish;
        end
    end

endmodule